// File: doc/BRIEF.md
# Trigger Interrupt and Error Flag Controller

This block sits beside a trigger-generation engine and turns its single-cycle event pulses into sticky flags that software can read and acknowledge. A master-reload strobe, eight trigger-event pulses and an ADC command pulse each set their own interrupt flag. An error flag records a sequential-mode overrun, which is an incoming event that arrives while the previous one is still waiting for its outgoing trigger. Each source drives its own interrupt output, gated by an enable bit.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational from the address. The two flag registers clear on a write of one, and writing zero leaves a bit unchanged. The enable register can be written at any time, because nothing protects it against writes. When the global DMA enable is set, each master-reload strobe also produces a one-cycle DMA request. That request does not depend on the state of the master-reload flag.

Top module: `trig_irq_flags`

## Requirements
- R1: After reset, every flag, every enable bit and the busy state are 0. All interrupt outputs and `dma_req` are 0, and reads at addresses 0, 1 and 2 return 0.
- R2: A pulse on `mrs_pulse`, `trig_pulse[i]` or `adc_cmd_pulse` sets its flag in the cycle after the pulse. The flag stays set until software clears it. The flag register is at address 0, with the master-reload flag in bit 0, trigger i in bit i+1 and the ADC command in bit 9.
- R3: Writing 1 to a bit at address 0, or to bit 0 at address 1, clears that flag. Writing 0 to a bit leaves it unchanged. Address 3 reads 0 and ignores writes.
- R4: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R5: Each of `irq_mrs`, `irq_trig[i]` and `irq_adc` equals its flag ANDed with its enable bit. The enable register is at address 2, and its bits 0 to 9 mirror the layout of the flag register.
- R6: In sequential mode (`seq_mode`=1), an incoming event sets the busy state, and any trigger pulse clears it. If an event and a trigger arrive in the same cycle, busy ends up set. An incoming event that arrives while busy is high sets the overrun flag, which is bit 0 at address 1.
- R7: Outside sequential mode, busy is held at 0 and incoming events never set the overrun flag.
- R8: `irq_err` equals the overrun flag ANDed with enable bit 10.
- R9: When enable bit 11 is set, `dma_req` pulses high for exactly the one cycle after each `mrs_pulse`, whether or not the master-reload flag is already set. When bit 11 is clear, `dma_req` stays 0.
- R10: The enable register can be written at any time and reads back the written value in bits 0 to 11. The unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_pulse | input | 1 | Master-reload strobe |
| trig_pulse | input | 8 | Outgoing trigger-event pulses |
| adc_cmd_pulse | input | 1 | ADC command pulse |
| in_event | input | 1 | Incoming event pulse |
| seq_mode | input | 1 | Sequential-mode configuration |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_addr` |
| irq_mrs | output | 1 | Master-reload interrupt |
| irq_trig | output | 8 | Per-trigger interrupts |
| irq_adc | output | 1 | ADC command interrupt |
| irq_err | output | 1 | Error-group interrupt |
| dma_req | output | 1 | DMA transfer request |

## Verification
A wrong busy state is never visible directly. It appears on the second incoming event: the overrun flag at address 1 and `irq_err` are set when they should stay clear, or stay clear when they should be set, one cycle after that event. A flag that fails to hold, or that clears on a zero write, shows up at the next read of address 0 and on its interrupt line in the same cycle. The bench keeps a cycle-accurate model of every flag and compares the full read word and all outputs after every clock. Any divergence is therefore reported within one cycle of the point where the design and the model split.

// File: rtl/trig_flag_pkg.sv
// Package: shared sizes, bit positions and register addresses
// for the trigger interrupt and error flag controller.
package trig_flag_pkg;
    localparam int NUM_TRIG = 8;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    // interrupt flag word: master reload, triggers, ADC command
    localparam int INT_W    = NUM_TRIG + 2;
    localparam int INT_MRS  = 0;
    localparam int INT_TRG0 = 1;
    localparam int INT_ADC  = NUM_TRIG + 1;
    // enable word: interrupt enables, then error enable and DMA enable
    localparam int EN_ERR   = INT_W;
    localparam int EN_DMA   = INT_W + 1;
    localparam int EN_W     = INT_W + 2;
    localparam int ERR_W    = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_INT  = 2'd0,
        ADDR_ERR  = 2'd1,
        ADDR_EN   = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/w1c_flag_bank.sv
// Module: bank of sticky flags, each set by hardware and cleared by
// software writing one. Assumes set_vec and clr_vec are synchronous
// single-cycle requests. A set and a clear in the same cycle leave the flag set.
module w1c_flag_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flags
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        // per-bit sticky flag, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_vec[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_busy_tracker.sv
// Module: tracks whether an incoming event is still waiting for its
// outgoing trigger in sequential mode, and flags an overrun when another
// event arrives while busy. Assumes all inputs are single-cycle pulses.
module seq_busy_tracker #(
    parameter int NUM_TRIG = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_mode,
    input  logic                in_event,
    input  logic [NUM_TRIG-1:0] trig_pulse,
    output logic                busy,
    output logic                overrun_set
);
    logic any_trig;

    // merge all trigger lines into one busy-clear request
    always_comb any_trig = |trig_pulse;

    // an overrun is an event that arrives while the previous one is pending
    always_comb overrun_set = seq_mode && in_event && busy;

    // busy state: an event sets it, a trigger clears it, and it is held low outside sequential mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (!seq_mode)
            busy <= 1'b0;
        else if (in_event)
            busy <= 1'b1;
        else if (any_trig)
            busy <= 1'b0;
    end
endmodule

// File: rtl/trig_irq_flags.sv
// Module: top level. Collects trigger-engine pulses into write-one-to-clear
// interrupt and error flags, gates them with enable bits onto separate
// interrupt lines, and issues a DMA request on master reload.
// Assumes a single register port with combinational reads and no write protection.
module trig_irq_flags
    import trig_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mrs_pulse,
    input  logic [NUM_TRIG-1:0] trig_pulse,
    input  logic                adc_cmd_pulse,
    input  logic                in_event,
    input  logic                seq_mode,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq_mrs,
    output logic [NUM_TRIG-1:0] irq_trig,
    output logic                irq_adc,
    output logic                irq_err,
    output logic                dma_req
);
    logic [INT_W-1:0] int_set, int_clr, int_flags;
    logic [ERR_W-1:0] err_set, err_clr, err_flags;
    logic [EN_W-1:0]  en_reg;
    logic             busy, overrun_set;
    logic [INT_W-1:0] int_gated;

    // gather the hardware set requests into the flag-word layout
    always_comb begin
        int_set                          = '0;
        int_set[INT_MRS]                 = mrs_pulse;
        int_set[INT_TRG0 +: NUM_TRIG]    = trig_pulse;
        int_set[INT_ADC]                 = adc_cmd_pulse;
        err_set                          = overrun_set;
    end

    // decode write-one-to-clear requests from the register port
    always_comb begin
        int_clr = (wr_en && reg_addr == ADDR_INT) ? wr_data[INT_W-1:0] : '0;
        err_clr = (wr_en && reg_addr == ADDR_ERR) ? wr_data[ERR_W-1:0] : '0;
    end

    w1c_flag_bank #(.WIDTH(INT_W)) u_int_flags (
        .clk(clk), .rst_n(rst_n),
        .set_vec(int_set), .clr_vec(int_clr), .flags(int_flags)
    );

    w1c_flag_bank #(.WIDTH(ERR_W)) u_err_flags (
        .clk(clk), .rst_n(rst_n),
        .set_vec(err_set), .clr_vec(err_clr), .flags(err_flags)
    );

    seq_busy_tracker #(.NUM_TRIG(NUM_TRIG)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .seq_mode(seq_mode), .in_event(in_event), .trig_pulse(trig_pulse),
        .busy(busy), .overrun_set(overrun_set)
    );

    // enable register, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_reg <= '0;
        else if (wr_en && reg_addr == ADDR_EN)
            en_reg <= wr_data[EN_W-1:0];
    end

    // one-cycle DMA request following a master reload, when globally enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_req <= 1'b0;
        else
            dma_req <= mrs_pulse && en_reg[EN_DMA];
    end

    // gate each flag with its enable onto its interrupt line
    always_comb begin
        int_gated = int_flags & en_reg[INT_W-1:0];
        irq_mrs   = int_gated[INT_MRS];
        irq_trig  = int_gated[INT_TRG0 +: NUM_TRIG];
        irq_adc   = int_gated[INT_ADC];
        irq_err   = (|err_flags) && en_reg[EN_ERR];
    end

    // combinational read multiplexer
    always_comb begin
        rd_data = '0;
        case (reg_addr)
            ADDR_INT: rd_data[INT_W-1:0] = int_flags;
            ADDR_ERR: rd_data[ERR_W-1:0] = err_flags;
            ADDR_EN:  rd_data[EN_W-1:0]  = en_reg;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/trig_irq_flags_chk.sv
// Module: property checker for trig_irq_flags, attached by bind.
// Assumes it sees the top's ports and a few internal state signals.
module trig_irq_flags_chk
    import trig_flag_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                mrs_pulse,
    input logic [NUM_TRIG-1:0] trig_pulse,
    input logic                adc_cmd_pulse,
    input logic                in_event,
    input logic                seq_mode,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                dma_req,
    input logic                irq_err,
    input logic                busy,
    input logic [INT_W-1:0]    int_flags,
    input logic [ERR_W-1:0]    err_flags,
    input logic [EN_W-1:0]     en_reg
);
    assert_adc_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flags[INT_ADC] && !(wr_en && reg_addr == ADDR_INT && wr_data[INT_ADC]))
        |=> int_flags[INT_ADC]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse[0] |=> int_flags[INT_TRG0]);

    assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && in_event && busy) |=> err_flags[0]);

    assert_no_busy_outside_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_mode |=> !busy);

    assert_err_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (err_flags[0] && en_reg[EN_ERR]));

    assert_dma_follows_mrs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_pulse && en_reg[EN_DMA]) |=> dma_req);

    assert_dma_needs_mrs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_pulse |=> !dma_req);

    assert_adc_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cmd_pulse |=> int_flags[INT_ADC]);
endmodule

bind trig_irq_flags trig_irq_flags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mrs_pulse(mrs_pulse), .trig_pulse(trig_pulse),
    .adc_cmd_pulse(adc_cmd_pulse), .in_event(in_event), .seq_mode(seq_mode),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .dma_req(dma_req),
    .irq_err(irq_err), .busy(busy), .int_flags(int_flags),
    .err_flags(err_flags), .en_reg(en_reg)
);

// File: tb/tb_trig_irq_flags.sv
// Bench: fixed-seed random stimulus plus directed corner cases, with every
// output compared after each clock against a model built from the requirements.
module tb_trig_irq_flags;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mrs_pulse, adc_cmd_pulse, in_event, seq_mode, wr_en;
    logic [7:0]  trig_pulse;
    logic [1:0]  reg_addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq_mrs, irq_adc, irq_err, dma_req;
    logic [7:0]  irq_trig;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // requirement model state
    logic [9:0]  m_int;
    logic        m_err;
    logic [11:0] m_en;
    logic        m_busy;
    logic        m_dma;

    always #2 clk = ~clk;

    trig_irq_flags dut (
        .clk(clk), .rst_n(rst_n), .mrs_pulse(mrs_pulse), .trig_pulse(trig_pulse),
        .adc_cmd_pulse(adc_cmd_pulse), .in_event(in_event), .seq_mode(seq_mode),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_mrs(irq_mrs), .irq_trig(irq_trig), .irq_adc(irq_adc),
        .irq_err(irq_err), .dma_req(dma_req)
    );

    function automatic logic [15:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {6'b0, m_int};
            2'd1: return {15'b0, m_err};
            2'd2: return {4'b0, m_en};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        mrs_pulse = 0; trig_pulse = 0; adc_cmd_pulse = 0; in_event = 0;
        wr_en = 0; wr_data = 0;
    endtask

    // one clock: advance the model from the driven inputs, then compare
    task automatic cycle();
        logic [9:0] set_v, clr_v;
        logic       eset, eclr;
        logic [1:0] a;
        a = reg_addr;
        @(posedge clk);
        set_v = {adc_cmd_pulse, trig_pulse, mrs_pulse};
        clr_v = (wr_en && reg_addr == 2'd0) ? wr_data[9:0] : 10'd0;
        eset  = seq_mode && in_event && m_busy;
        eclr  = wr_en && reg_addr == 2'd1 && wr_data[0];
        m_dma = mrs_pulse && m_en[11];
        m_int = (m_int & ~clr_v) | set_v;
        m_err = eset ? 1'b1 : (eclr ? 1'b0 : m_err);
        m_busy = !seq_mode ? 1'b0 : (in_event ? 1'b1 : ((|trig_pulse) ? 1'b0 : m_busy));
        if (wr_en && reg_addr == 2'd2) m_en = wr_data[11:0];
        @(negedge clk);
        chk("R2/R3 read word", rd_data, exp_read(a));
        chk("R5 irq_mrs", irq_mrs, m_int[0] & m_en[0]);
        chk("R5 irq_trig", irq_trig, m_int[8:1] & m_en[8:1]);
        chk("R5 irq_adc", irq_adc, m_int[9] & m_en[9]);
        chk("R8 irq_err", irq_err, m_err & m_en[10]);
        chk("R9 dma_req", dma_req, m_dma);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        idle(); wr_en = 1; reg_addr = a; wr_data = d; cycle(); idle();
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        idle(); reg_addr = a; #0;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(); seq_mode = 1; reg_addr = 0; rst_n = 0;
        m_int = 0; m_err = 0; m_en = 0; m_busy = 0; m_dma = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd_chk("R1 flags", 2'd0, 16'h0);
        rd_chk("R1 errors", 2'd1, 16'h0);
        rd_chk("R1 enables", 2'd2, 16'h0);
        chk("R1 outputs", {irq_mrs, irq_trig, irq_adc, irq_err, dma_req}, 0);

        // R10: enable write and readback, upper bits read 0
        wr(2'd2, 16'hFFFF);
        rd_chk("R10 enable readback", 2'd2, 16'h0FFF);

        // R2: each source sets its flag
        idle(); mrs_pulse = 1; trig_pulse = 8'h81; adc_cmd_pulse = 1; cycle(); idle();
        rd_chk("R2 flags set", 2'd0, 16'h0303);
        cycle();
        rd_chk("R2 flags sticky", 2'd0, 16'h0303);

        // R3: zero write no effect, one write clears
        wr(2'd0, 16'h0000);
        rd_chk("R3 zero write", 2'd0, 16'h0303);
        wr(2'd0, 16'h0002);
        rd_chk("R3 one write clears", 2'd0, 16'h0301);

        // R4: set and clear in same cycle
        idle(); trig_pulse = 8'h01; adc_cmd_pulse = 1; wr_en = 1; reg_addr = 0;
        wr_data = 16'h0202; cycle(); idle();
        rd_chk("R4 set wins", 2'd0, 16'h0303);

        // R6: overrun in sequential mode, then clear
        seq_mode = 1;
        idle(); in_event = 1; cycle();
        in_event = 1; cycle(); idle();
        rd_chk("R6 overrun", 2'd1, 16'h0001);
        chk("R8 irq_err on", irq_err, 1'b1);
        wr(2'd1, 16'h0001);
        rd_chk("R3 error clears", 2'd1, 16'h0000);
        // trigger clears busy: event, trigger, event gives no overrun
        idle(); trig_pulse = 8'h10; cycle(); idle();
        in_event = 1; cycle(); idle();
        trig_pulse = 8'h20; cycle(); idle();
        in_event = 1; cycle(); idle();
        rd_chk("R6 trigger clears busy", 2'd1, 16'h0000);
        idle(); trig_pulse = 8'h01; cycle(); idle();

        // R7: outside sequential mode no overrun, busy held low
        seq_mode = 0;
        idle(); in_event = 1; cycle(); cycle(); cycle(); idle();
        rd_chk("R7 no overrun", 2'd1, 16'h0000);
        seq_mode = 1; in_event = 1; cycle(); idle();
        rd_chk("R7 busy was held low", 2'd1, 16'h0000);
        idle(); trig_pulse = 8'h01; cycle(); idle();

        // R9: DMA with flag already set, then disabled
        idle(); mrs_pulse = 1; cycle(); idle();
        chk("R9 dma pulse", dma_req, 1'b1);
        cycle();
        chk("R9 dma one cycle", dma_req, 1'b0);
        wr(2'd2, 16'h03FF);
        idle(); mrs_pulse = 1; cycle(); idle();
        chk("R9 dma disabled", dma_req, 1'b0);
        wr(2'd3, 16'hFFFF);
        rd_chk("R3 addr3 reads zero", 2'd3, 16'h0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            mrs_pulse     = ($urandom % 6) == 0;
            adc_cmd_pulse = ($urandom % 6) == 0;
            in_event      = ($urandom % 3) == 0;
            trig_pulse    = (($urandom % 4) == 0) ? (8'h1 << ($urandom % 8)) : 8'h0;
            if (($urandom % 40) == 0) seq_mode = ~seq_mode;
            reg_addr = 2'($urandom % 4);
            if (($urandom % 4) == 0) begin
                wr_en = 1;
                wr_data = 16'($urandom);
            end
            cycle();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule